// File: doc/BRIEF.md
# UART FIFO Control with Transmit Trigger

This block is the byte-buffering layer of a serial port. It holds a transmit byte queue filled by software and drained by the serializer, and a receive byte queue filled by the deserializer and drained by software. Each queue is first-word-fall-through: the oldest byte is always on its read-data output. A small register port holds a control register and a one-bit status register.

The control register picks a transmit trigger level, carries one flush bit for each queue, and enables an internal loopback. A sticky transmit-data-empty flag rises whenever the transmit fill count is at or below the chosen level. Software clears the flag by writing 0 to the status register, and the clear only takes effect while the fill count is above the level. In loopback the serializer output feeds the deserializer input and the external transmit pin idles high.

Each queue runs a state machine with states LN_EMPTY, LN_ACTIVE, LN_FULL and LN_FLUSH. Any state goes to LN_FLUSH while the flush input is 1. Otherwise the state follows the next count: 0 gives LN_EMPTY, the depth gives LN_FULL, and any other count gives LN_ACTIVE. This is how LN_FLUSH returns to LN_EMPTY or LN_ACTIVE once the flush bit is released. The flag machine has two states. FLG_RAISED goes to FLG_CLEARED on a clear request while the count is above the level. FLG_CLEARED goes back to FLG_RAISED as soon as the count is at or below the level.

Top module: `uart_fifo_ctl`

## Requirements
- R1: Each queue holds 16 bytes and returns them in the order they were pushed, and its count output gives the number of bytes held.
- R2: A push to a full queue is dropped and the count stays 16. A pop from an empty queue leaves the count at 0, and read data is 0 whenever the queue is empty.
- R3: A push and a pop in the same cycle leave the count unchanged when it is 1 to 15. At count 0 only the push is taken, and at count 16 only the pop is taken.
- R4: Control bits [5:4] select the transmit level: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 0.
- R5: One cycle after the transmit count is at or below the selected level, the transmit-data-empty flag is 1.
- R6: The flag is sticky. Writing status (address 1) with bit 0 = 0 clears it only if the transmit count is above the level in that cycle. Writing bit 0 = 1 has no effect.
- R7: Control bit 2 set to 1 empties the transmit queue one cycle later and keeps it at count 0. Pushes are ignored while the bit stays 1, and the receive queue is unaffected.
- R8: Control bit 1 set to 1 does the same for the receive queue, independently of the transmit queue.
- R9: With control bit 0 = 1, `ser_rx_out` follows `ser_tx_in` and `txd_pin` is 1. With bit 0 = 0, `ser_rx_out` follows `rxd_pin` and `txd_pin` follows `ser_tx_in`.
- R10: The control register reads at address 0 as {2'b00, level[1:0], 1'b0, txflush, rxflush, loop}. Bit 3 and bits 7:6 always read 0. The status register reads at address 1 as {7'b0, flag}.
- R11: Reset empties both queues, clears the control register to 0 and leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Serializer takes the head transmit byte |
| tx_rdata | output | 8 | Head transmit byte, 0 when empty |
| tx_count | output | 5 | Transmit fill count |
| rx_push | input | 1 | Deserializer pushes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Software takes the head receive byte |
| rx_rdata | output | 8 | Head receive byte, 0 when empty |
| rx_count | output | 5 | Receive fill count |
| ser_tx_in | input | 1 | Serial line from the serializer |
| txd_pin | output | 1 | External transmit pin |
| rxd_pin | input | 1 | External receive pin |
| ser_rx_out | output | 1 | Serial line to the deserializer |
| tx_empty_flag | output | 1 | Sticky transmit-data-empty flag |

## Verification
The assertions assume that every strobe and data input is a defined 0 or 1 that changes only between rising edges, and that reset is asserted before the first edge. They also assume that the push and pop strobes may take any value at any count, including overflow and underflow attempts, because the block itself must reject illegal moves. The bench drives all inputs on the falling edge and holds reset low for several cycles at start-up. It deliberately pushes into full queues, pops from empty ones and toggles flush bits with traffic in flight, so the assertions see their boundary conditions and not only quiet traffic.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        LN_EMPTY  = 2'd0,
        LN_ACTIVE = 2'd1,
        LN_FULL   = 2'd2,
        LN_FLUSH  = 2'd3
    } lane_state_e;

    typedef enum logic {
        FLG_RAISED  = 1'b0,
        FLG_CLEARED = 1'b1
    } flag_state_e;

    // Transmit level for each two-bit code, scaled to the queue depth.
    function automatic int unsigned trig_level(input logic [1:0] code,
                                               input int unsigned depth);
        int unsigned lvl;
        case (code)
            2'b00:   lvl = depth / 2;
            2'b01:   lvl = depth / 4;
            2'b10:   lvl = depth / 8;
            default: lvl = 0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/uart_fifo_lane.sv
module uart_fifo_lane
    import uart_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         pop,
    output logic [DATA_W-1:0]            rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    lane_state_e        state_q, state_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
    logic               acc_push, acc_pop;
    logic [DATA_W-1:0]  mem [DEPTH];

    // Which moves the current state allows.
    always_comb begin
        acc_push = 1'b0;
        acc_pop  = 1'b0;
        unique case (state_q)
            LN_EMPTY, LN_FLUSH: acc_push = push;
            LN_ACTIVE: begin
                acc_push = push;
                acc_pop  = pop;
            end
            LN_FULL:   acc_pop = pop;
            default:   ;
        endcase
        if (flush) begin
            acc_push = 1'b0;
            acc_pop  = 1'b0;
        end
    end

    // Next count and next state.
    always_comb begin
        if (flush)
            cnt_n = '0;
        else if (acc_push && !acc_pop)
            cnt_n = cnt_q + 1'b1;
        else if (acc_pop && !acc_push)
            cnt_n = cnt_q - 1'b1;
        else
            cnt_n = cnt_q;

        if (flush)
            state_n = LN_FLUSH;
        else if (cnt_n == '0)
            state_n = LN_EMPTY;
        else if (cnt_n == CNT_FULL)
            state_n = LN_FULL;
        else
            state_n = LN_ACTIVE;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LN_EMPTY;
        else
            state_q <= state_n;
    end

    // Count and pointers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            cnt_q <= cnt_n;
            if (flush) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (acc_push)
                    wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
                if (acc_pop)
                    rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
        end
    end

    // Storage.
    always_ff @(posedge clk) begin
        if (acc_push)
            mem[wr_ptr_q] <= wdata;
    end

    // Outputs.
    always_comb begin
        count = cnt_q;
        unique case (state_q)
            LN_ACTIVE, LN_FULL: rdata = mem[rd_ptr_q];
            default:            rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic                        reg_addr,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  reg_rdata,
    input  logic [$clog2(DEPTH+1)-1:0]  tx_count,
    output logic [1:0]                  trig,
    output logic                        tx_flush,
    output logic                        rx_flush,
    output logic                        loop_en,
    output logic                        tx_empty_flag
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]       trig_q;
    logic             txf_q, rxf_q, loop_q;
    logic [CNT_W-1:0] thr;
    logic             above, clr_req, ctl_wr;
    flag_state_e      flg_q, flg_n;

    assign ctl_wr  = reg_we && !reg_addr;
    assign clr_req = reg_we && reg_addr && !reg_wdata[0];
    assign thr     = CNT_W'(trig_level(trig_q, DEPTH));
    assign above   = tx_count > thr;

    // Control register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 2'b00;
            txf_q  <= 1'b0;
            rxf_q  <= 1'b0;
            loop_q <= 1'b0;
        end else if (ctl_wr) begin
            trig_q <= reg_wdata[5:4];
            txf_q  <= reg_wdata[2];
            rxf_q  <= reg_wdata[1];
            loop_q <= reg_wdata[0];
        end
    end

    // Flag machine: next state.
    always_comb begin
        flg_n = flg_q;
        unique case (flg_q)
            FLG_RAISED:  if (above && clr_req) flg_n = FLG_CLEARED;
            FLG_CLEARED: if (!above)           flg_n = FLG_RAISED;
            default:     flg_n = FLG_RAISED;
        endcase
    end

    // Flag machine: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flg_q <= FLG_RAISED;
        else
            flg_q <= flg_n;
    end

    // Outputs.
    always_comb begin
        trig          = trig_q;
        tx_flush      = txf_q;
        rx_flush      = rxf_q;
        loop_en       = loop_q;
        tx_empty_flag = (flg_q == FLG_RAISED);
        if (reg_addr)
            reg_rdata = {7'b0, tx_empty_flag};
        else
            reg_rdata = {2'b00, trig_q, 1'b0, txf_q, rxf_q, loop_q};
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic                        reg_addr,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  reg_rdata,
    input  logic                        tx_push,
    input  logic [DATA_W-1:0]           tx_wdata,
    input  logic                        tx_pop,
    output logic [DATA_W-1:0]           tx_rdata,
    output logic [$clog2(DEPTH+1)-1:0]  tx_count,
    input  logic                        rx_push,
    input  logic [DATA_W-1:0]           rx_wdata,
    input  logic                        rx_pop,
    output logic [DATA_W-1:0]           rx_rdata,
    output logic [$clog2(DEPTH+1)-1:0]  rx_count,
    input  logic                        ser_tx_in,
    output logic                        txd_pin,
    input  logic                        rxd_pin,
    output logic                        ser_rx_out,
    output logic                        tx_empty_flag
);

    logic [1:0] trig;
    logic       tx_flush, rx_flush, loop_en;

    uart_fifo_regs #(.DEPTH(DEPTH)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .tx_count      (tx_count),
        .trig          (trig),
        .tx_flush      (tx_flush),
        .rx_flush      (rx_flush),
        .loop_en       (loop_en),
        .tx_empty_flag (tx_empty_flag)
    );

    uart_fifo_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_count)
    );

    uart_fifo_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_count)
    );

    // Loopback routing.
    always_comb begin
        if (loop_en) begin
            txd_pin    = 1'b1;
            ser_rx_out = ser_tx_in;
        end else begin
            txd_pin    = ser_tx_in;
            ser_rx_out = rxd_pin;
        end
    end

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk
    import uart_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic                        reg_addr,
    input logic [7:0]                  reg_wdata,
    input logic [7:0]                  reg_rdata,
    input logic                        tx_push,
    input logic                        tx_pop,
    input logic [DATA_W-1:0]           tx_rdata,
    input logic [$clog2(DEPTH+1)-1:0]  tx_count,
    input logic [DATA_W-1:0]           rx_rdata,
    input logic [$clog2(DEPTH+1)-1:0]  rx_count,
    input logic                        ser_tx_in,
    input logic                        txd_pin,
    input logic                        ser_rx_out,
    input logic                        tx_empty_flag,
    input logic [1:0]                  trig,
    input logic                        tx_flush,
    input logic                        rx_flush,
    input logic                        loop_en
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] lvl;
    logic             clr_wr;
    assign lvl    = CNT_W'(trig_level(trig, DEPTH));
    assign clr_wr = reg_we && reg_addr && !reg_wdata[0];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_FULL) && (rx_count <= CNT_FULL)); // R1

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == CNT_FULL && tx_push && !tx_pop && !tx_flush) |=> (tx_count == CNT_FULL)); // R2

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> (tx_rdata == '0)); // R2

    AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> (rx_rdata == '0)); // R2

    AST_SIMUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_pop && !tx_flush && tx_count != '0 && tx_count != CNT_FULL)
        |=> $stable(tx_count)); // R3

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= lvl) |=> tx_empty_flag); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty_flag && !clr_wr) |=> tx_empty_flag); // R6

    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_count == '0)); // R7

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_count == '0)); // R8

    AST_LOOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (txd_pin && ser_rx_out == ser_tx_in)); // R9

    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> (reg_rdata[3] == 1'b0 && reg_rdata[7:6] == 2'b00)); // R10

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .tx_push       (tx_push),
    .tx_pop        (tx_pop),
    .tx_rdata      (tx_rdata),
    .tx_count      (tx_count),
    .rx_rdata      (rx_rdata),
    .rx_count      (rx_count),
    .ser_tx_in     (ser_tx_in),
    .txd_pin       (txd_pin),
    .ser_rx_out    (ser_rx_out),
    .tx_empty_flag (tx_empty_flag),
    .trig          (trig),
    .tx_flush      (tx_flush),
    .rx_flush      (rx_flush),
    .loop_en       (loop_en)
);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
    logic [4:0] tx_count, rx_count;
    logic       ser_tx_in = 1'b1, rxd_pin = 1'b1, txd_pin, ser_rx_out, tx_empty_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_fifo_ctl i_uart_fifo_ctl (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_count(tx_count),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_count(rx_count),
        .ser_tx_in(ser_tx_in), .txd_pin(txd_pin), .rxd_pin(rxd_pin), .ser_rx_out(ser_rx_out),
        .tx_empty_flag(tx_empty_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic tx_put(input logic [7:0] d);
        tx_push = 1'b1; tx_wdata = d;
        step();
        tx_push = 1'b0;
    endtask

    task automatic tx_get(output logic [7:0] d);
        d = tx_rdata;
        tx_pop = 1'b1;
        step();
        tx_pop = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] d);
        rx_push = 1'b1; rx_wdata = d;
        step();
        rx_push = 1'b0;
    endtask

    task automatic flush_both();
        reg_write(1'b0, 8'h06);
        reg_write(1'b0, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_read(1'b0, v);
        chk("R11 ctrl after reset", v, 0);
        reg_read(1'b1, v);
        chk("R11 status flag after reset", v, 1);
        chk("R11 tx count after reset", tx_count, 0);
        chk("R11 rx count after reset", rx_count, 0);
        chk("R2 rx read data empty", rx_rdata, 0);
    endtask

    task automatic t_order();
        logic [7:0] d;
        tx_put(8'hA1); tx_put(8'hB2); tx_put(8'hC3);
        chk("R1 count after three pushes", tx_count, 3);
        tx_get(d); chk("R1 first byte", d, 8'hA1);
        tx_get(d); chk("R1 second byte", d, 8'hB2);
        tx_get(d); chk("R1 third byte", d, 8'hC3);
        chk("R1 count after drain", tx_count, 0);
    endtask

    task automatic t_full_empty();
        logic [7:0] d;
        for (int i = 0; i < 17; i++) tx_put(8'(8'h10 + i));
        chk("R2 count after overfill", tx_count, 16);
        for (int i = 0; i < 16; i++) begin
            tx_get(d);
            chk("R2 drain order", d, 8'h10 + i);
        end
        tx_get(d);
        chk("R2 pop empty returns 0", d, 0);
        chk("R2 count after empty pop", tx_count, 0);
    endtask

    task automatic t_simul();
        for (int i = 0; i < 5; i++) tx_put(8'(i));
        tx_push = 1'b1; tx_pop = 1'b1; tx_wdata = 8'h55;
        step();
        tx_push = 1'b0; tx_pop = 1'b0;
        chk("R3 push+pop mid count", tx_count, 5);
        flush_both();
        tx_push = 1'b1; tx_pop = 1'b1; tx_wdata = 8'h66;
        step();
        tx_push = 1'b0; tx_pop = 1'b0;
        chk("R3 push+pop at empty", tx_count, 1);
        chk("R3 byte kept at empty", tx_rdata, 8'h66);
        for (int i = 0; i < 15; i++) tx_put(8'(i));
        tx_push = 1'b1; tx_pop = 1'b1;
        step();
        tx_push = 1'b0; tx_pop = 1'b0;
        chk("R3 push+pop at full", tx_count, 15);
        flush_both();
    endtask

    task automatic t_trigger();
        logic [7:0] d;
        int lvls [4] = '{8, 4, 2, 0};
        for (int c = 0; c < 4; c++) begin
            reg_write(1'b0, 8'(c << 4) | 8'h04);
            reg_write(1'b0, 8'(c << 4));
            for (int i = 0; i <= lvls[c]; i++) tx_put(8'(i));
            step();
            chk("R5 flag still set before clear", tx_empty_flag, 1);
            reg_write(1'b1, 8'h01);
            chk("R6 writing 1 does not clear", tx_empty_flag, 1);
            reg_write(1'b1, 8'h00);
            step();
            chk("R6 clear above level", tx_empty_flag, 0);
            tx_get(d);
            step();
            chk("R4 R5 flag at level", tx_empty_flag, 1);
            reg_write(1'b1, 8'h00);
            step();
            chk("R6 clear ignored at level", tx_empty_flag, 1);
        end
        reg_write(1'b0, 8'h04);
        reg_write(1'b0, 8'h00);
    endtask

    task automatic t_flush();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) tx_put(8'(i));
        for (int i = 0; i < 3; i++) rx_put(8'(i + 1));
        reg_write(1'b0, 8'h04);
        step();
        chk("R7 tx emptied", tx_count, 0);
        chk("R7 rx untouched", rx_count, 3);
        tx_put(8'h77);
        chk("R7 push ignored while flushing", tx_count, 0);
        reg_read(1'b0, v);
        chk("R10 ctrl readback tx flush", v, 8'h04);
        reg_write(1'b0, 8'h00);
        tx_put(8'h78);
        chk("R7 push after release", tx_count, 1);
        chk("R7 data after release", tx_rdata, 8'h78);
        reg_write(1'b0, 8'h02);
        step();
        chk("R8 rx emptied", rx_count, 0);
        chk("R8 tx untouched", tx_count, 1);
        rx_put(8'h99);
        chk("R8 push ignored while flushing", rx_count, 0);
        reg_write(1'b0, 8'h00);
        rx_put(8'h9A);
        chk("R8 rx push after release", rx_rdata, 8'h9A);
        flush_both();
    endtask

    task automatic t_loop();
        reg_write(1'b0, 8'h01);
        ser_tx_in = 1'b0; rxd_pin = 1'b1; #1;
        chk("R9 loop routes tx to rx", ser_rx_out, 0);
        chk("R9 loop pin idles high", txd_pin, 1);
        ser_tx_in = 1'b1; rxd_pin = 1'b0; #1;
        chk("R9 loop follows tx high", ser_rx_out, 1);
        reg_write(1'b0, 8'h00);
        ser_tx_in = 1'b0; rxd_pin = 1'b1; #1;
        chk("R9 normal pin follows tx", txd_pin, 0);
        chk("R9 normal rx from pin", ser_rx_out, 1);
        ser_tx_in = 1'b1;
    endtask

    task automatic t_ctrl_bits();
        logic [7:0] v;
        reg_write(1'b0, 8'hFF);
        reg_read(1'b0, v);
        chk("R10 reserved bits read 0", v, 8'h37);
        reg_write(1'b0, 8'h00);
        reg_read(1'b0, v);
        chk("R10 ctrl cleared", v, 0);
    endtask

    task automatic t_mid_reset();
        logic [7:0] v;
        reg_write(1'b0, 8'h31);
        for (int i = 0; i < 6; i++) tx_put(8'(i));
        rx_put(8'h42);
        reg_write(1'b1, 8'h00);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R11 tx count after reset", tx_count, 0);
        chk("R11 rx count after reset", rx_count, 0);
        chk("R11 flag after reset", tx_empty_flag, 1);
        reg_read(1'b0, v);
        chk("R11 ctrl after reset", v, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_order();
        t_full_empty();
        t_simul();
        t_trigger();
        t_flush();
        t_loop();
        t_ctrl_bits();
        t_mid_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule